// File: doc/BRIEF.md
# I2C Address Phase Sequencer

This block runs the address phase of an I2C master transaction. It sits on top of a byte engine that can put one byte on the bus, or generate a repeated start, and that reports completion together with the acknowledge bit it sampled. A request carries a 10-bit address field, a flag that selects 10-bit addressing and a read/write flag. The block formats the address bytes and hands them to the engine one step at a time. It inserts a repeated start where 10-bit reads need one, and it checks the acknowledge of every address byte.

A 7-bit address takes a single byte. A 10-bit write takes a header byte carrying the two top address bits, then the low eight bits. A 10-bit read continues after those two bytes with a repeated start and a second header whose direction bit is set. All of this runs as one automatic sequence. When a sequence ends, the block gives a one-cycle completion pulse for success, or a one-cycle error pulse if a byte was not acknowledged or the engine did not answer in time. The data phase and bus timing are handled elsewhere.

Top module: `i2c_addr_seq`

## Requirements
- R1: After a synchronous reset, busy_o, done_o, err_o and eng_cmd_valid_o are all low.
- R2: In 7-bit mode (ten_bit_i=0) exactly one byte command is issued, with byte value {addr_i[6:0], rd_i}, followed by a done pulse; no repeated start is requested.
- R3: In 10-bit mode the first byte command carries 8'b11110 in bits 7:3, addr_i[9:8] in bits 2:1 and 0 in bit 0.
- R4: In 10-bit mode the second byte command carries addr_i[7:0]; for a write (rd_i=0) the sequence then completes with a done pulse after exactly two commands.
- R5: In 10-bit read mode the two bytes are followed by a repeated-start command (eng_cmd_rstart_o=1), then the header byte again with bit 0 set to 1, then a done pulse: four commands in total.
- R6: If the engine completes an address byte with eng_nack_i=1, the sequence aborts with an err_o pulse, no done pulse, and no further command is issued.
- R7: If eng_done_i does not arrive within TMO_CYCLES cycles, counting from the cycle in which the command is presented, the sequence aborts with an err_o pulse and issues no further command; an answer in the last of those cycles is still accepted.
- R8: done_o and err_o are single-cycle pulses, never high together, and each accepted request produces exactly one of them.
- R9: A request made while a sequence is running is ignored: the bytes of the running sequence are unchanged and no extra sequence follows.
- R10: Each command is shown on eng_cmd_valid_o for exactly one cycle, and the next command is issued only after eng_done_i for the previous one; busy_o stays high until the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start an address phase (taken only when idle) |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| rd_i | input | 1 | 1 for a read transfer |
| addr_i | input | ADDR_W | Target address; 7-bit mode uses bits 6:0 |
| eng_cmd_valid_o | output | 1 | One-cycle command strobe to the byte engine |
| eng_cmd_rstart_o | output | 1 | 1 = repeated start, 0 = send eng_byte_o |
| eng_byte_o | output | 8 | Byte to send |
| eng_done_i | input | 1 | Engine finished the current command |
| eng_nack_i | input | 1 | Acknowledge sampled as NAK, valid with eng_done_i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: address phase acknowledged |
| err_o | output | 1 | One-cycle pulse: NAK or timeout |

## Verification
Each of the three addressing shapes is driven: 7-bit reads and writes, which tell apart the shift and the direction bit; a 10-bit write, which must stop after two bytes; and a 10-bit read, which must show the repeated start and the flipped direction bit. Addresses such as 0x2A5 and 0x3C8 put different values in bits 9:8, so a swapped or dropped top bit shows in the header. NAKs are placed on the first, second and resent header bytes, to show that the abort happens at whichever step fails. Engine answers at the last allowed cycle and no answer at all separate the acceptance edge of the timeout. A request made in the middle of a sequence shows that the latched address is protected.

// File: rtl/i2c_aseq_pkg.sv
package i2c_aseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HDR   = 3'd1,
    ST_LOW   = 3'd2,
    ST_RSTRT = 3'd3,
    ST_RHDR  = 3'd4,
    ST_DONE  = 3'd5,
    ST_ERR   = 3'd6
  } aseq_state_t;

  // Fixed top five bits of a 10-bit address header byte.
  localparam logic [4:0] TEN_HDR_PREFIX = 5'b11110;

  // True for states that hand a command to the byte engine.
  function automatic logic is_step(aseq_state_t s);
    return (s == ST_HDR) || (s == ST_LOW) || (s == ST_RSTRT) || (s == ST_RHDR);
  endfunction

  // True for states whose command transmits an address byte.
  function automatic logic is_byte_step(aseq_state_t s);
    return (s == ST_HDR) || (s == ST_LOW) || (s == ST_RHDR);
  endfunction

endpackage

// File: rtl/aseq_req_latch.sv
module aseq_req_latch #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              busy_i,
  input  logic              ten_bit_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ten_bit_q,
  output logic              rd_q,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ten_bit_q <= 1'b0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
    end else if (accept_i) begin
      ten_bit_q <= ten_bit_i;
      rd_q      <= rd_i;
      addr_q    <= addr_i;
    end
  end

  // R9: the captured request cannot move while a sequence is running
  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> ($stable(addr_q) && $stable(rd_q) && $stable(ten_bit_q)));

endmodule

// File: rtl/aseq_byte_fmt.sv
module aseq_byte_fmt
  import i2c_aseq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  aseq_state_t       state_i,
  input  logic              ten_bit_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        byte_o
);

  logic [1:0] top_bits;
  logic [7:0] hdr_write;

  assign top_bits  = addr_i[9:8];
  assign hdr_write = {TEN_HDR_PREFIX, top_bits, 1'b0};

  always_comb begin
    byte_o = 8'h00;
    unique case (state_i)
      ST_HDR:  byte_o = ten_bit_i ? hdr_write : {addr_i[6:0], rd_i};
      ST_LOW:  byte_o = addr_i[7:0];
      ST_RHDR: byte_o = {hdr_write[7:1], 1'b1};
      default: byte_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/aseq_step_timer.sv
module aseq_step_timer #(
  parameter int TMO_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/aseq_ctrl.sv
module aseq_ctrl
  import i2c_aseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_i,
  input  logic        ten_bit_q,
  input  logic        rd_q,
  input  logic [7:0]  fmt_byte_i,
  input  logic        eng_done_i,
  input  logic        eng_nack_i,
  input  logic        tmo_expired_i,
  output aseq_state_t state_o,
  output logic        accept_o,
  output logic        issue_o,
  output logic        waiting_o,
  output logic        cmd_valid_o,
  output logic        cmd_rstart_o,
  output logic [7:0]  cmd_byte_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);

  aseq_state_t state_q, state_d, next_ok;
  logic        issued_q;

  assign state_o   = state_q;
  assign waiting_o = issued_q && is_step(state_q);

  // Successor of a step that completed cleanly.
  always_comb begin
    next_ok = ST_IDLE;
    unique case (state_q)
      ST_HDR:   next_ok = ten_bit_q ? ST_LOW : ST_DONE;
      ST_LOW:   next_ok = rd_q ? ST_RSTRT : ST_DONE;
      ST_RSTRT: next_ok = ST_RHDR;
      ST_RHDR:  next_ok = ST_DONE;
      default:  next_ok = ST_IDLE;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    issue_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          state_d  = ST_HDR;
        end
      end
      ST_HDR, ST_LOW, ST_RSTRT, ST_RHDR: begin
        if (!issued_q) begin
          issue_o = 1'b1;
        end else if (eng_done_i) begin
          state_d = (is_byte_step(state_q) && eng_nack_i) ? ST_ERR : next_ok;
        end else if (tmo_expired_i) begin
          state_d = ST_ERR;
        end
      end
      ST_DONE, ST_ERR: state_d = ST_IDLE;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      issued_q     <= 1'b0;
      cmd_valid_o  <= 1'b0;
      cmd_rstart_o <= 1'b0;
      cmd_byte_o   <= 8'h00;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      state_q     <= state_d;
      cmd_valid_o <= issue_o;
      if (issue_o) begin
        issued_q     <= 1'b1;
        cmd_rstart_o <= (state_q == ST_RSTRT);
        cmd_byte_o   <= fmt_byte_i;
      end else if (state_d != state_q) begin
        issued_q <= 1'b0;
      end
      busy_o <= (state_d != ST_IDLE);
      done_o <= (state_d == ST_DONE);
      err_o  <= (state_d == ST_ERR);
    end
  end

  // R8: completion pulses are exclusive and last one cycle
  a_r8_done_err_excl: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
  // R10: a command strobe is one cycle wide and only while busy
  a_r10_cmd_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);
  a_r10_cmd_busy: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> busy_o);
  // R6: a NAK on an address byte leads to an error pulse
  a_r6_nack_abort: assert property (@(posedge clk) disable iff (rst)
    (waiting_o && is_byte_step(state_q) && eng_done_i && eng_nack_i) |=> (err_o && !done_o));
  // R7: an expired step issues nothing further
  a_r7_tmo_abort: assert property (@(posedge clk) disable iff (rst)
    (waiting_o && tmo_expired_i && !eng_done_i) |=> (err_o && !cmd_valid_o));

endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_aseq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int TMO_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              ten_bit_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              eng_cmd_valid_o,
  output logic              eng_cmd_rstart_o,
  output logic [7:0]        eng_byte_o,
  input  logic              eng_done_i,
  input  logic              eng_nack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  aseq_state_t       state;
  logic              accept, issue, waiting, expired;
  logic              ten_q, rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        fmt_byte;

  aseq_req_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (accept),
    .busy_i    (busy_o),
    .ten_bit_i (ten_bit_i),
    .rd_i      (rd_i),
    .addr_i    (addr_i),
    .ten_bit_q (ten_q),
    .rd_q      (rd_q),
    .addr_q    (addr_q)
  );

  aseq_byte_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .state_i   (state),
    .ten_bit_i (ten_q),
    .rd_i      (rd_q),
    .addr_i    (addr_q),
    .byte_o    (fmt_byte)
  );

  aseq_step_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .start_i   (issue),
    .run_i     (waiting),
    .expired_o (expired)
  );

  aseq_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_i         (req_i),
    .ten_bit_q     (ten_q),
    .rd_q          (rd_q),
    .fmt_byte_i    (fmt_byte),
    .eng_done_i    (eng_done_i),
    .eng_nack_i    (eng_nack_i),
    .tmo_expired_i (expired),
    .state_o       (state),
    .accept_o      (accept),
    .issue_o       (issue),
    .waiting_o     (waiting),
    .cmd_valid_o   (eng_cmd_valid_o),
    .cmd_rstart_o  (eng_cmd_rstart_o),
    .cmd_byte_o    (eng_byte_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o)
  );

endmodule

// File: tb/i2c_addr_seq_test.sv
`timescale 1ns/1ps
module i2c_addr_seq_test;

  localparam int TMO = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0, ten = 1'b0, rd = 1'b0;
  logic [9:0] addr = '0;
  logic       cmd_valid, cmd_rstart;
  logic [7:0] cmd_byte;
  logic       eng_done = 1'b0, eng_nack = 1'b0;
  logic       busy, done, err;

  always #2 clk = ~clk;

  i2c_addr_seq #(.ADDR_W(10), .TMO_CYCLES(TMO)) uut (
    .clk(clk), .rst(rst), .req_i(req), .ten_bit_i(ten), .rd_i(rd), .addr_i(addr),
    .eng_cmd_valid_o(cmd_valid), .eng_cmd_rstart_o(cmd_rstart), .eng_byte_o(cmd_byte),
    .eng_done_i(eng_done), .eng_nack_i(eng_nack),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int vectors = 0, miscompares = 0;
  int n_cmd = 0, done_cnt = 0, err_cnt = 0;
  int eng_lat = 3;
  int nack_at = -1;
  logic [7:0] log_byte [0:15];
  logic       log_rs   [0:15];

  // Byte engine model: answers each command eng_lat cycles later (0 = never).
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid && n_cmd < 16) begin
        int idx;
        idx = n_cmd;
        log_byte[idx] = cmd_byte;
        log_rs[idx]   = cmd_rstart;
        n_cmd++;
        if (eng_lat > 0) begin
          repeat (eng_lat) @(negedge clk);
          eng_done = 1'b1;
          eng_nack = (idx == nack_at);
          @(negedge clk);
          eng_done = 1'b0;
          eng_nack = 1'b0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (err)  err_cnt++;
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic start_seq(input logic t, input logic r, input logic [9:0] a,
                           input int lat, input int nk);
    @(negedge clk);
    n_cmd = 0; done_cnt = 0; err_cnt = 0;
    eng_lat = lat; nack_at = nk;
    req = 1'b1; ten = t; rd = r; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done_cnt + err_cnt > 0) break;
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic expect_cmd(input int i, input logic rs, input logic [7:0] b, input string rq);
    check(log_rs[i] == rs, rq, int'(log_rs[i]), int'(rs));
    if (!rs) check(log_byte[i] == b, rq, int'(log_byte[i]), int'(b));
  endtask

  task automatic t_reset();
    check(!busy && !done && !err && !cmd_valid, "R1",
          {busy, done, err, cmd_valid}, 0);
  endtask

  task automatic t_seven_bit();
    start_seq(1'b0, 1'b1, 10'h050, 3, -1);
    wait_end();
    check(n_cmd == 1, "R2", n_cmd, 1);
    expect_cmd(0, 1'b0, 8'hA1, "R2");
    check(done_cnt == 1 && err_cnt == 0, "R2", done_cnt, 1);
    check(!busy, "R10", busy, 0);
    start_seq(1'b0, 1'b0, 10'h37F, 2, -1);
    wait_end();
    check(n_cmd == 1, "R2", n_cmd, 1);
    expect_cmd(0, 1'b0, 8'hFE, "R2");
    check(done_cnt == 1, "R8", done_cnt, 1);
  endtask

  task automatic t_ten_write();
    start_seq(1'b1, 1'b0, 10'h3C8, 3, -1);
    wait_end();
    check(n_cmd == 2, "R4", n_cmd, 2);
    expect_cmd(0, 1'b0, 8'hF6, "R3");
    expect_cmd(1, 1'b0, 8'hC8, "R4");
    check(done_cnt == 1 && err_cnt == 0, "R4", done_cnt, 1);
  endtask

  task automatic t_ten_read();
    start_seq(1'b1, 1'b1, 10'h2A5, 4, -1);
    wait_end();
    check(n_cmd == 4, "R5", n_cmd, 4);
    expect_cmd(0, 1'b0, 8'hF4, "R3");
    expect_cmd(1, 1'b0, 8'hA5, "R4");
    expect_cmd(2, 1'b1, 8'h00, "R5");
    expect_cmd(3, 1'b0, 8'hF5, "R5");
    check(done_cnt == 1 && err_cnt == 0, "R5", done_cnt, 1);
  endtask

  task automatic t_nack();
    start_seq(1'b0, 1'b0, 10'h022, 2, 0);
    wait_end();
    check(n_cmd == 1, "R6", n_cmd, 1);
    check(err_cnt == 1 && done_cnt == 0, "R6", err_cnt, 1);
    start_seq(1'b1, 1'b1, 10'h1F0, 2, 1);
    wait_end();
    check(n_cmd == 2, "R6", n_cmd, 2);
    check(err_cnt == 1 && done_cnt == 0, "R6", err_cnt, 1);
    start_seq(1'b1, 1'b1, 10'h1F0, 2, 3);
    wait_end();
    check(n_cmd == 4, "R6", n_cmd, 4);
    expect_cmd(3, 1'b0, 8'hF3, "R6");
    check(err_cnt == 1 && done_cnt == 0, "R6", err_cnt, 1);
  endtask

  task automatic t_timeout();
    start_seq(1'b1, 1'b0, 10'h155, TMO - 1, -1);
    wait_end();
    check(n_cmd == 2 && done_cnt == 1 && err_cnt == 0, "R7", done_cnt, 1);
    start_seq(1'b1, 1'b0, 10'h155, 0, -1);
    wait_end();
    check(n_cmd == 1, "R7", n_cmd, 1);
    check(err_cnt == 1 && done_cnt == 0, "R7", err_cnt, 1);
    check(!busy, "R7", busy, 0);
  endtask

  task automatic t_busy_ignore();
    start_seq(1'b1, 1'b1, 10'h2A5, 3, -1);
    repeat (4) @(negedge clk);
    check(busy, "R10", busy, 1);
    req = 1'b1; ten = 1'b0; rd = 1'b0; addr = 10'h0FF;
    @(negedge clk);
    req = 1'b0;
    wait_end();
    check(n_cmd == 4, "R9", n_cmd, 4);
    expect_cmd(0, 1'b0, 8'hF4, "R9");
    expect_cmd(1, 1'b0, 8'hA5, "R9");
    expect_cmd(3, 1'b0, 8'hF5, "R9");
    check(done_cnt == 1 && err_cnt == 0, "R9", done_cnt, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_seven_bit();
    t_ten_write();
    t_ten_read();
    t_nack();
    t_timeout();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule